// File: doc/BRIEF.md
# Raster to 8x8 Block Buffer

This block sits between a pixel source and a block-based image frontend that share one clock. The source delivers pixels as consecutive rows of eight. The block collects each group of eight rows into one of four block-sized stores. It then plays every stored block back, one pixel per cycle, as three back-to-back passes before moving on to the next block. The three passes let a downstream stage with three parallel consumers, such as one per colour component, see the same block in turn.

Four stores let the source fill one block while earlier blocks are still being replayed. Each replay takes three times as long as a fill, so the source eventually gets ahead. The block then raises a plain `stop_source` flag. `stop_source` works as an inverted ready: a pixel is taken on a rising edge only when `pix_valid` is high and `stop_source` is low. A source that sees `stop_source` high keeps its pixel and offers it again later. The flag rises once all four stores are full. It falls only after three stores have been fully replayed and released since it rose. Between these two points the source sees long, steady bursts and the output never starves. The output side has no back-pressure: the sink takes a pixel on every cycle in which `out_valid` is high.

Top module: `raster_block_buffer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_last` and `stop_source` are low.
- R2: Accepted pixels fill a store in row-major order, eight per row, so the k-th accepted pixel of a block (k = 0..63) goes to position k. In every pass, position k of the block is output as the k-th pixel.
- R3: Each stored block is output as three consecutive passes of 64 pixels, 192 valid cycles in all. `out_last` is high exactly on position 63 of each pass.
- R4: Stores are filled and replayed in circular order 0, 1, 2, 3, so blocks come out in the order they arrived.
- R5: `out_valid` rises one clock after the rising edge that accepts the 64th pixel of a block, when no earlier block is still being replayed.
- R6: Once a complete block is stored, `out_valid` stays high with no gap, both within a pass and across pass and block boundaries, as long as the next block is complete in time.
- R7: `stop_source` rises on the edge at which the fourth store becomes full. It is high whenever all four stores are full.
- R8: After it rises, `stop_source` stays high until the edge that releases the third store since it rose, and falls on that edge.
- R9: A pixel offered while `stop_source` is high is ignored. It never appears on the output and does not advance the write position.
- R10: A pixel offered while `pix_valid` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by source, block and sink |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Source offers a pixel this cycle |
| pix_data | input | PIX_W | Pixel value |
| stop_source | output | 1 | Source must hold off; offered pixels are not taken |
| out_valid | output | 1 | `out_data` carries a block pixel this cycle |
| out_data | output | PIX_W | Block pixel, row-major within the block |
| out_last | output | 1 | Last pixel of the current pass |

## Verification
On every cycle, the assertions check several properties. `out_last` only appears with `out_valid`. A pass never breaks before its last pixel. Each rise of `stop_source` follows a completed fill, and each fall follows a store release. The flag is high whenever all stores are full. Offers made while stopped or while invalid leave the write position unchanged. Some properties need the bench's scenarios and its cycle-level reference model: that the data really is the accepted pixels in row-major order, three times over, in arrival order; the first-output latency; the hysteresis count of exactly three releases; and the absence of gaps across block boundaries under a fast source.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;

  // Bit width able to index n items; never below one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Bit width able to hold the value n itself.
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/blkbuf_wr_gen.sv
module blkbuf_wr_gen
  import blkbuf_pkg::*;
#(
  parameter int BLK  = 8,
  parameter int NBUF = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept,
  output logic [idx_width(NBUF)-1:0]    wr_buf,
  output logic [idx_width(BLK*BLK)-1:0] wr_addr,
  output logic                          wr_done
);
  localparam int CW = idx_width(BLK);
  localparam int AW = idx_width(BLK*BLK);
  localparam int BW = idx_width(NBUF);

  logic [CW-1:0] col_q, row_q;
  logic [BW-1:0] buf_q;
  logic          col_end, row_end;

  assign col_end = (col_q == CW'(BLK-1));
  assign row_end = (row_q == CW'(BLK-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      buf_q <= '0;
    end else if (accept) begin
      if (col_end) begin
        col_q <= '0;
        if (row_end) begin
          row_q <= '0;
          buf_q <= (buf_q == BW'(NBUF-1)) ? '0 : buf_q + 1'b1;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign wr_buf  = buf_q;
  assign wr_addr = AW'(row_q) * AW'(BLK) + AW'(col_q);
  assign wr_done = accept && col_end && row_end;

endmodule

// File: rtl/blkbuf_rd_seq.sv
module blkbuf_rd_seq
  import blkbuf_pkg::*;
#(
  parameter int BLK     = 8,
  parameter int NBUF    = 4,
  parameter int REPLAYS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NBUF-1:0]               full,
  output logic [idx_width(NBUF)-1:0]    rd_buf,
  output logic [idx_width(BLK*BLK)-1:0] rd_addr,
  output logic                          rd_fire,
  output logic                          rd_pass_end,
  output logic                          rd_release
);
  localparam int BLK_SZ = BLK * BLK;
  localparam int AW     = idx_width(BLK_SZ);
  localparam int BW     = idx_width(NBUF);
  localparam int RW     = idx_width(REPLAYS);

  logic [AW-1:0] pos_q;
  logic [RW-1:0] rep_q;
  logic [BW-1:0] buf_q;
  logic          rep_end;

  assign rd_fire     = full[buf_q];
  assign rd_pass_end = rd_fire && (pos_q == AW'(BLK_SZ-1));
  assign rep_end     = (rep_q == RW'(REPLAYS-1));
  assign rd_release  = rd_pass_end && rep_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      rep_q <= '0;
      buf_q <= '0;
    end else if (rd_fire) begin
      if (rd_pass_end) begin
        pos_q <= '0;
        if (rep_end) begin
          rep_q <= '0;
          buf_q <= (buf_q == BW'(NBUF-1)) ? '0 : buf_q + 1'b1;
        end else begin
          rep_q <= rep_q + 1'b1;
        end
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign rd_buf  = buf_q;
  assign rd_addr = pos_q;

endmodule

// File: rtl/blkbuf_flow.sv
module blkbuf_flow
  import blkbuf_pkg::*;
#(
  parameter int NBUF        = 4,
  parameter int RELEASE_CNT = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fill_done,
  input  logic [idx_width(NBUF)-1:0] fill_buf,
  input  logic                       drain_done,
  input  logic [idx_width(NBUF)-1:0] drain_buf,
  output logic [NBUF-1:0]            full,
  output logic [cnt_width(NBUF)-1:0] fill_cnt,
  output logic                       stop
);
  localparam int CNTW = cnt_width(NBUF);
  localparam int RCW  = idx_width(RELEASE_CNT);

  logic [NBUF-1:0] full_q;
  logic [CNTW-1:0] cnt_q, cnt_nxt;
  logic [RCW-1:0]  relc_q;
  logic            stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
    end else begin
      for (int b = 0; b < NBUF; b++) begin
        if (fill_done && (int'(fill_buf) == b)) begin
          full_q[b] <= 1'b1;
        end else if (drain_done && (int'(drain_buf) == b)) begin
          full_q[b] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (fill_done && !drain_done) begin
      cnt_nxt = cnt_q + 1'b1;
    end else if (!fill_done && drain_done) begin
      cnt_nxt = cnt_q - 1'b1;
    end
  end

  // Hysteresis: set on reaching all-full, clear after RELEASE_CNT drains.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      relc_q <= '0;
      stop_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (!stop_q) begin
        if (cnt_nxt == CNTW'(NBUF)) begin
          stop_q <= 1'b1;
          relc_q <= '0;
        end
      end else if (drain_done) begin
        if (relc_q == RCW'(RELEASE_CNT-1)) begin
          stop_q <= 1'b0;
          relc_q <= '0;
        end else begin
          relc_q <= relc_q + 1'b1;
        end
      end
    end
  end

  assign full     = full_q;
  assign fill_cnt = cnt_q;
  assign stop     = stop_q;

endmodule

// File: rtl/blkbuf_store.sv
module blkbuf_store
  import blkbuf_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int BLK_SZ = 64,
  parameter int NBUF   = 4
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [idx_width(NBUF)-1:0] wsel,
  input  logic [idx_width(BLK_SZ)-1:0] waddr,
  input  logic [PIX_W-1:0]           wdata,
  input  logic [idx_width(NBUF)-1:0] rsel,
  input  logic [idx_width(BLK_SZ)-1:0] raddr,
  output logic [PIX_W-1:0]           rdata
);
  logic [PIX_W-1:0] bank_rd [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_bank
    logic [PIX_W-1:0] mem [BLK_SZ];
    always_ff @(posedge clk) begin
      if (we && (int'(wsel) == b)) begin
        mem[waddr] <= wdata;
      end
    end
    assign bank_rd[b] = mem[raddr];
  end

  assign rdata = bank_rd[rsel];

endmodule

// File: rtl/raster_block_buffer.sv
module raster_block_buffer
  import blkbuf_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int BLK         = 8,
  parameter int NBUF        = 4,
  parameter int REPLAYS     = 3,
  parameter int RELEASE_CNT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             stop_source,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_last
);
  localparam int BLK_SZ = BLK * BLK;
  localparam int AW     = idx_width(BLK_SZ);
  localparam int BW     = idx_width(NBUF);
  localparam int CNTW   = cnt_width(NBUF);

  logic             accept;
  logic [BW-1:0]    wr_buf, rd_buf;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic             wr_done;
  logic [NBUF-1:0]  full;
  logic [CNTW-1:0]  fill_cnt;
  logic             rd_fire, rd_pass_end, rd_release;
  logic [PIX_W-1:0] rd_data;
  logic             ov_q, ol_q;
  logic [PIX_W-1:0] od_q;

  assign accept = pix_valid && !stop_source;

  blkbuf_wr_gen #(.BLK(BLK), .NBUF(NBUF)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .wr_buf  (wr_buf),
    .wr_addr (wr_addr),
    .wr_done (wr_done)
  );

  blkbuf_rd_seq #(.BLK(BLK), .NBUF(NBUF), .REPLAYS(REPLAYS)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .full        (full),
    .rd_buf      (rd_buf),
    .rd_addr     (rd_addr),
    .rd_fire     (rd_fire),
    .rd_pass_end (rd_pass_end),
    .rd_release  (rd_release)
  );

  blkbuf_flow #(.NBUF(NBUF), .RELEASE_CNT(RELEASE_CNT)) u_flow (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_done  (wr_done),
    .fill_buf   (wr_buf),
    .drain_done (rd_release),
    .drain_buf  (rd_buf),
    .full       (full),
    .fill_cnt   (fill_cnt),
    .stop       (stop_source)
  );

  blkbuf_store #(.PIX_W(PIX_W), .BLK_SZ(BLK_SZ), .NBUF(NBUF)) u_mem (
    .clk   (clk),
    .we    (accept),
    .wsel  (wr_buf),
    .waddr (wr_addr),
    .wdata (pix_data),
    .rsel  (rd_buf),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= rd_fire;
      ol_q <= rd_pass_end;
      if (rd_fire) begin
        od_q <= rd_data;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_last  = ol_q;
  assign out_data  = od_q;

endmodule

// File: rtl/blkbuf_chk.sv
module blkbuf_chk #(
  parameter int NBUF = 4,
  parameter int AW   = 6,
  parameter int BW   = 2,
  parameter int CNTW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pix_valid,
  input logic            stop_source,
  input logic            out_valid,
  input logic            out_last,
  input logic            wr_done,
  input logic            rd_release,
  input logic [AW-1:0]   wr_addr,
  input logic [BW-1:0]   wr_buf,
  input logic [CNTW-1:0] fill_cnt
);

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R3

  AST_PASS_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid); // R6

  AST_STOP_RISE_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_source) |-> $past(wr_done)); // R7

  AST_ALL_FULL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill_cnt) == NBUF) |-> stop_source); // R7

  AST_STOP_FALL_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_source) |-> $past(rd_release)); // R8

  AST_STOPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_source |=> ($stable(wr_addr) && $stable(wr_buf))); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> ($stable(wr_addr) && $stable(wr_buf))); // R10

endmodule

bind raster_block_buffer blkbuf_chk #(
  .NBUF (NBUF),
  .AW   (AW),
  .BW   (BW),
  .CNTW (CNTW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pix_valid   (pix_valid),
  .stop_source (stop_source),
  .out_valid   (out_valid),
  .out_last    (out_last),
  .wr_done     (wr_done),
  .rd_release  (rd_release),
  .wr_addr     (wr_addr),
  .wr_buf      (wr_buf),
  .fill_cnt    (fill_cnt)
);

// File: tb/sim_raster_block_buffer.sv
`timescale 1ns/1ps
module sim_raster_block_buffer;
  localparam int BLK_SZ = 64;
  localparam logic [7:0] JUNK_STOP = 8'hEE;
  localparam logic [7:0] JUNK_IDLE = 8'hF0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = 8'h00;
  logic       stop_source, out_valid, out_last;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  int seq = 0;

  always #5 clk = ~clk;

  raster_block_buffer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .stop_source (stop_source),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of stored pixels, block in progress, stop hysteresis.
  int  mpix[$];
  int  wb[$];
  bit  m_stop, m_valid, m_last;
  int  m_data, m_rel, m_rpos, m_rrep, m_before;
  bit  m_done, m_drain;

  always @(posedge clk) begin
    if (!rst_n) begin
      mpix.delete(); wb.delete();
      m_stop = 0; m_valid = 0; m_last = 0; m_data = 0;
      m_rel = 0; m_rpos = 0; m_rrep = 0;
    end else begin
      m_before = mpix.size() / BLK_SZ;
      m_done = 0; m_drain = 0;
      if (m_before > 0) begin
        m_valid = 1;
        m_data  = mpix[m_rpos];
        m_last  = (m_rpos == BLK_SZ - 1);
        if (m_rpos == BLK_SZ - 1) begin
          m_rpos = 0;
          if (m_rrep == 2) begin
            m_rrep = 0;
            m_drain = 1;
            for (int i = 0; i < BLK_SZ; i++) void'(mpix.pop_front());
          end else begin
            m_rrep++;
          end
        end else begin
          m_rpos++;
        end
      end else begin
        m_valid = 0;
        m_last  = 0;
      end
      if (pix_valid && !m_stop) begin
        wb.push_back(int'(pix_data));
        if (wb.size() == BLK_SZ) begin
          foreach (wb[i]) mpix.push_back(wb[i]);
          wb.delete();
          m_done = 1;
        end
      end
      if (!m_stop) begin
        if (m_before + int'(m_done) - int'(m_drain) == 4) begin
          m_stop = 1;
          m_rel = 0;
        end
      end else if (m_drain) begin
        m_rel++;
        if (m_rel == 3) m_stop = 0;
      end
    end
  end

  // Per-cycle comparison and scenario monitors.
  int  last_cnt = 0;
  int  junk_seen = 0;
  int  idle_seen = 0;
  int  stop_rises = 0;
  bit  prev_stop = 0;
  bit  watch_gap = 0;
  bit  seen_valid = 0;
  int  gaps = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == m_valid, "R6 out_valid", int'(out_valid), int'(m_valid));
      if (m_valid) begin
        chk(int'(out_data) == m_data, "R2 out_data", int'(out_data), m_data);
        chk(out_last == m_last, "R3 out_last", int'(out_last), int'(m_last));
      end
      chk(stop_source == m_stop, "R7 stop_source", int'(stop_source), int'(m_stop));
      if (out_valid && out_last) last_cnt++;
      if (out_valid && out_data == JUNK_STOP) junk_seen++;
      if (out_valid && out_data == JUNK_IDLE) idle_seen++;
      if (stop_source && !prev_stop) stop_rises++;
      prev_stop = stop_source;
      if (watch_gap) begin
        if (out_valid) seen_valid = 1;
        else if (seen_valid) gaps++;
      end
    end
  end

  // Pixel values stay in 1..200 so both junk markers are distinguishable.
  function automatic logic [7:0] pix_val(input int s);
    return 8'((s * 7) % 200 + 1);
  endfunction

  // mode 0: valid only when not stopped; 1: periodic idle cycles; 2: junk offered while stopped
  task automatic feed(input int npix, input int mode);
    int sent = 0;
    int cyc = 0;
    while (sent < npix) begin
      @(negedge clk);
      if (stop_source) begin
        pix_valid = (mode != 0);
        pix_data  = JUNK_STOP;
      end else if (mode == 1 && (cyc % 3) == 2) begin
        pix_valid = 1'b0;
        pix_data  = JUNK_IDLE;
      end else begin
        pix_valid = 1'b1;
        pix_data  = pix_val(seq);
        seq++;
        sent++;
      end
      cyc++;
    end
    @(negedge clk);
    pix_valid = 1'b0;
    pix_data  = JUNK_IDLE;
  endtask

  task automatic drain();
    int n = 0;
    while ((mpix.size() > 0 || out_valid) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(10 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(stop_source == 0, "R1 stop in reset", int'(stop_source), 0);
    chk(out_last == 0, "R1 out_last in reset", int'(out_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(stop_source == 0, "R1 stop after reset", int'(stop_source), 0);

    // R5: first block latency; feed() leaves us at the negedge after the accepting edge
    feed(BLK_SZ, 0);
    chk(out_valid == 0, "R5 not yet valid", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1, "R5 valid one clock later", int'(out_valid), 1);

    // R2/R4: two more blocks in order with a steady source
    feed(2 * BLK_SZ, 0);
    drain();
    chk(last_cnt == 9, "R3 pass count three blocks", last_cnt, 9);

    // R7/R8/R9/R6: fast source with junk while stopped
    last_cnt = 0;
    watch_gap = 1;
    feed(8 * BLK_SZ, 2);
    watch_gap = 0;
    chk(stop_rises >= 1, "R7 stop asserted", stop_rises, 1);
    chk(gaps == 0, "R6 no output gaps", gaps, 0);
    drain();
    chk(last_cnt == 24, "R3 pass count eight blocks", last_cnt, 24);
    chk(stop_source == 0, "R8 stop released when drained", int'(stop_source), 0);
    chk(junk_seen == 0, "R9 stopped offers absent", junk_seen, 0);

    // R10: gappy source
    last_cnt = 0;
    feed(6 * BLK_SZ, 1);
    drain();
    chk(last_cnt == 18, "R3 pass count gappy", last_cnt, 18);
    chk(idle_seen == 0, "R10 invalid offers absent", idle_seen, 0);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule